// File: doc/BRIEF.md
# Periodic Waveform Frame Driver for a Serial 10-bit DAC

This block sits on the host side of a serial voltage-output converter. It plays a periodic waveform into that converter with no software involvement. An internal down-counter sets the sample rate. On every expiry, the block takes the next sample from one of two sources: a stepping ramp, or a 32-point sine table whose index wraps. It packs the sample together with the speed and power-down control bits into a 16-bit word. It then runs one framed serial transfer on four wires: an active-low select, an active-low frame strobe, a serial clock and a data line.

The transfer always follows the same order. Select falls first, then the frame strobe falls, then sixteen bits are clocked out most significant first, then the strobe rises, then select rises. All phases are timed in system clocks. A single parameter sets the serial-clock half period, and elaboration rejects a value that would make the serial clock faster than the converter tolerates. A byte-wide option adds a pause after the eighth bit, so the word goes out as two 8-bit bursts under one strobe. A timer expiry that lands while a transfer is still running is dropped and reported on a one-cycle flag.

Top module: `wavedac_driver`

## Requirements
- R1: While reset is asserted and after it is released, until the first frame starts, `dac_cs_n_o` and `dac_fs_n_o` are high, while `dac_sclk_o`, `dac_sdo_o` and `overrun_o` are low. The ramp code and the table index both start at zero.
- R2: The sample timer expires every `reload_i`+1 system clocks, with the first expiry in the first cycle after reset. Each expiry that finds the driver idle starts exactly one frame. Consecutive select falling edges are therefore `reload_i`+1 cycles apart whenever a frame fits in the period.
- R3: A frame runs in this order: select falls; frame strobe falls; sixteen falling serial-clock edges; strobe rises; select rises. Select stays low during the whole strobe-low period, and the serial clock is high only while the strobe is low.
- R4: Each serial-clock high phase and low phase lasts `CLK_HALF` system clocks. With the `CLK_NS` clock period, each phase is at least 25 ns. Other phases also last at least `CLK_HALF` cycles: select-to-strobe, strobe-to-first-falling-edge, data setup before a falling edge, data hold after it, last-falling-edge-to-strobe-rise and strobe-high-before-select-rise. These give at least 10, 8, 8, 5, 10 and 20 ns respectively.
- R5: The word is sent most significant bit first, and the converter samples each bit on a falling serial-clock edge. The word layout is: bit 15 = 0, bit 14 = `fast_i`, bit 13 = `pdown_i`, bit 12 = 0, bits 11..2 = the 10-bit code, and bits 1..0 = 0.
- R6: With `sine_sel_i` = 0, the code is the ramp value. The ramp value increases by one after every frame sent in ramp mode, so the word rises by 4. It wraps from 1023 to 0, and it does not move during sine frames.
- R7: With `sine_sel_i` = 1, the code is round(512 + 511·sin(2πk/32)) for table index k. The index advances by one per sine frame, wraps from 31 to 0, and does not move during ramp frames.
- R8: With `byte_mode_i` = 1, the serial clock stays low for 2·`CLK_HALF` cycles between the eighth falling edge and the ninth rising edge; otherwise that gap is `CLK_HALF`. Both bytes are sent within one strobe-low period.
- R9: When an expiry arrives while a frame is in progress, `overrun_o` pulses high for one cycle in the next cycle. No frame is queued and the sample source does not advance, so the next frame sends the value that was due.
- R10: The mode, byte option and control bits are taken at the expiry that starts a frame. Changing these inputs during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload_i | input | TIMER_W | Sample period minus one, in system clocks |
| sine_sel_i | input | 1 | 0 selects the ramp source, 1 selects the sine table |
| byte_mode_i | input | 1 | 1 splits the word into two 8-bit bursts |
| fast_i | input | 1 | Speed control bit placed in word bit 14 |
| pdown_i | input | 1 | Power-down control bit placed in word bit 13 |
| dac_cs_n_o | output | 1 | Active-low converter select |
| dac_fs_n_o | output | 1 | Active-low frame strobe |
| dac_sclk_o | output | 1 | Serial clock, idles low |
| dac_sdo_o | output | 1 | Serial data to the converter |
| overrun_o | output | 1 | One-cycle pulse for a dropped timer expiry |

## Verification
A monitor decodes each frame from the four wires alone. It checks every phase width against the nanosecond limits and compares the received word with a model of both sources. The stimulus walks several mode patterns: plain ramp, ramp with control bits, sine with power-down, byte-wide sine and byte-wide ramp. It also includes a sine run long enough to cross the table wrap. Together these separate the control-bit placement, the per-source index bookkeeping and the byte gap timing. Directed tests change the inputs in the middle of a frame to show they are captured at the expiry. They also shorten the period below the frame length to expose dropped expiries without a skipped sample. A second instance with a one-cycle half period steps the ramp through its 1023-to-0 wrap within the run budget.

// File: rtl/wavedac_pkg.sv
package wavedac_pkg;

  localparam int WORD_W = 16;
  localparam int CODE_W = 10;
  localparam int IDX_W  = 5;
  localparam int BITCNT_W = $clog2(WORD_W);

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_SEL_LEAD,
    FR_STB_LEAD,
    FR_CLK_HI,
    FR_CLK_LO,
    FR_BYTE_GAP,
    FR_STB_TAIL
  } frame_state_e;

  // Word layout: {0, speed, power-down, 0, code[9:0], 00}
  function automatic logic [WORD_W-1:0] pack_word(input logic fast,
                                                  input logic pdown,
                                                  input logic [CODE_W-1:0] code);
    return {1'b0, fast, pdown, 1'b0, code, 2'b00};
  endfunction

endpackage

// File: rtl/wavedac_timer.sv
module wavedac_timer #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIMER_W-1:0] reload_i,
  output logic               tick_o
);

  logic [TIMER_W-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == '0);

  always_comb begin
    if (tick_o) cnt_d = reload_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wavedac_source.sv
module wavedac_source
  import wavedac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              sine_sel_i,
  output logic [CODE_W-1:0] code_o
);

  logic [CODE_W-1:0] ramp_q, ramp_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              ramp_en, idx_en;

  // 512 + 511*sin(2*pi*k/32), rounded; second half mirrors the first
  function automatic logic [CODE_W-1:0] sine_point(input logic [IDX_W-1:0] k);
    logic [8:0] mag;
    logic [3:0] q;
    q = k[3:0];
    case (q[3] ? (4'd16 - q) : q)
      4'd0:    mag = 9'd0;
      4'd1:    mag = 9'd100;
      4'd2:    mag = 9'd196;
      4'd3:    mag = 9'd284;
      4'd4:    mag = 9'd361;
      4'd5:    mag = 9'd425;
      4'd6:    mag = 9'd472;
      4'd7:    mag = 9'd501;
      default: mag = 9'd511;
    endcase
    if (k[4]) return 10'd512 - {1'b0, mag};
    else      return 10'd512 + {1'b0, mag};
  endfunction

  assign ramp_en = adv_i && !sine_sel_i;
  assign idx_en  = adv_i &&  sine_sel_i;

  always_comb begin
    ramp_d = ramp_q + 1'b1;
    idx_d  = idx_q + 1'b1;
    code_o = sine_sel_i ? sine_point(idx_q) : ramp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q <= '0;
      idx_q  <= '0;
    end else begin
      if (ramp_en) ramp_q <= ramp_d;
      if (idx_en)  idx_q  <= idx_d;
    end
  end

endmodule

// File: rtl/wavedac_shifter.sv
module wavedac_shifter
  import wavedac_pkg::*;
#(
  parameter int HALF = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              byte_i,
  output logic              busy_o,
  output logic              cs_n_o,
  output logic              fs_n_o,
  output logic              sclk_o,
  output logic              sdo_o
);

  localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LOAD = DIV_W'(HALF - 1);

  frame_state_e        state_q, state_d;
  logic [DIV_W-1:0]    div_q, div_d;
  logic [BITCNT_W-1:0] bit_q, bit_d;
  logic [WORD_W-1:0]   sreg_q, sreg_d;
  logic                byte_q, byte_d;
  logic                cs_n_q, fs_n_q, sclk_q;
  logic                cs_n_d, fs_n_d, sclk_d;
  logic                phase_end;

  assign phase_end = (div_q == '0);
  assign busy_o    = (state_q != FR_IDLE);

  always_comb begin
    state_d = state_q;
    div_d   = div_q;
    bit_d   = bit_q;
    sreg_d  = sreg_q;
    byte_d  = byte_q;
    if (state_q == FR_IDLE) begin
      if (start_i) begin
        state_d = FR_SEL_LEAD;
        div_d   = DIV_LOAD;
        bit_d   = '0;
        sreg_d  = word_i;
        byte_d  = byte_i;
      end
    end else if (!phase_end) begin
      div_d = div_q - 1'b1;
    end else begin
      div_d = DIV_LOAD;
      case (state_q)
        FR_SEL_LEAD: state_d = FR_STB_LEAD;
        FR_STB_LEAD: state_d = FR_CLK_HI;
        FR_CLK_HI:   state_d = FR_CLK_LO;
        FR_BYTE_GAP: state_d = FR_CLK_HI;
        FR_CLK_LO: begin
          if (bit_q == BITCNT_W'(WORD_W - 1)) begin
            state_d = FR_STB_TAIL;
          end else begin
            bit_d   = bit_q + 1'b1;
            sreg_d  = {sreg_q[WORD_W-2:0], 1'b0};
            state_d = (byte_q && bit_q == BITCNT_W'(WORD_W/2 - 1)) ? FR_BYTE_GAP : FR_CLK_HI;
          end
        end
        default: state_d = FR_IDLE;
      endcase
    end
  end

  always_comb begin
    cs_n_d = (state_d == FR_IDLE);
    fs_n_d = !(state_d inside {FR_STB_LEAD, FR_CLK_HI, FR_CLK_LO, FR_BYTE_GAP});
    sclk_d = (state_d == FR_CLK_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      div_q   <= '0;
      bit_q   <= '0;
      sreg_q  <= '0;
      byte_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      fs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      div_q   <= div_d;
      bit_q   <= bit_d;
      sreg_q  <= sreg_d;
      byte_q  <= byte_d;
      cs_n_q  <= cs_n_d;
      fs_n_q  <= fs_n_d;
      sclk_q  <= sclk_d;
    end
  end

  assign cs_n_o = cs_n_q;
  assign fs_n_o = fs_n_q;
  assign sclk_o = sclk_q;
  assign sdo_o  = sreg_q[WORD_W-1];

endmodule

// File: rtl/wavedac_driver.sv
module wavedac_driver
  import wavedac_pkg::*;
#(
  parameter int TIMER_W  = 16,
  parameter int CLK_HALF = 7,
  parameter int CLK_NS   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIMER_W-1:0] reload_i,
  input  logic               sine_sel_i,
  input  logic               byte_mode_i,
  input  logic               fast_i,
  input  logic               pdown_i,
  output logic               dac_cs_n_o,
  output logic               dac_fs_n_o,
  output logic               dac_sclk_o,
  output logic               dac_sdo_o,
  output logic               overrun_o
);

  localparam int MIN_HALF_NS = 25;

  if (CLK_HALF < 1 || CLK_HALF * CLK_NS < MIN_HALF_NS) begin : g_half_check
    $error("serial clock half period below 25 ns");
  end

  logic              tick, busy, start;
  logic              overrun_q, overrun_d;
  logic [CODE_W-1:0] code;
  logic [WORD_W-1:0] word;

  assign start     = tick && !busy;
  assign overrun_d = tick && busy;
  assign word      = pack_word(fast_i, pdown_i, code);

  wavedac_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload_i (reload_i),
    .tick_o   (tick)
  );

  wavedac_source u_source (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (start),
    .sine_sel_i (sine_sel_i),
    .code_o     (code)
  );

  wavedac_shifter #(.HALF(CLK_HALF)) u_shifter (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .word_i  (word),
    .byte_i  (byte_mode_i),
    .busy_o  (busy),
    .cs_n_o  (dac_cs_n_o),
    .fs_n_o  (dac_fs_n_o),
    .sclk_o  (dac_sclk_o),
    .sdo_o   (dac_sdo_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun_q <= 1'b0;
    else        overrun_q <= overrun_d;
  end

  assign overrun_o = overrun_q;

endmodule

// File: rtl/wavedac_checker.sv
module wavedac_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic fs_n,
  input logic sclk,
  input logic sdo,
  input logic overrun
);

  AST_STROBE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_n |-> !cs_n); // R3

  AST_CLOCK_INSIDE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !fs_n); // R3

  AST_SELECT_LEADS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> fs_n); // R4

  AST_STROBE_RISE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_n) |-> !sclk && !$past(sclk)); // R4

  AST_DATA_STABLE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(sdo)); // R5

  AST_OVERRUN_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(!cs_n)); // R9

endmodule

bind wavedac_driver wavedac_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (dac_cs_n_o),
  .fs_n    (dac_fs_n_o),
  .sclk    (dac_sclk_o),
  .sdo     (dac_sdo_o),
  .overrun (overrun_o)
);

// File: tb/tb_wavedac_driver.sv
module tb_frame_mon #(
  parameter int NS_PER = 4,
  parameter bit CHK    = 1'b1
) (
  input  logic        clk,
  input  logic        cs_n,
  input  logic        fs_n,
  input  logic        sclk,
  input  logic        sdo,
  output int          frames_o,
  output logic [15:0] word_o,
  output int          falls_o,
  output int          low8_o,
  output int          period_o,
  output int          viol_o
);
  int cyc = 0, frames = 0, falls = 0, low8 = 0, period = 0, viol = 0;
  int t_csf = -1, t_fs = 0, t_rise = 0, t_fall = 0, t_d = 0, t_fsr = 0, nf = 0, l8 = 0;
  logic [15:0] w = '0, word = '0;
  logic pcs = 1'b1, pfs = 1'b1, psclk = 1'b0, psdo = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!cs_n && pcs) begin
      if (t_csf >= 0) period = cyc - t_csf;
      t_csf = cyc;
    end
    if (!fs_n && pfs) begin
      if (CHK && (cyc - t_csf) * NS_PER < 10) viol++;
      t_fs = cyc; nf = 0; w = '0;
    end
    if (sdo !== psdo) begin
      if (CHK && !fs_n && nf > 0 && (cyc - t_fall) * NS_PER < 5) viol++;
      t_d = cyc;
    end
    if (sclk && !psclk) begin
      if (CHK && nf > 0 && (cyc - t_fall) * NS_PER < 25) viol++;
      if (nf == 8) l8 = cyc - t_fall;
      t_rise = cyc;
    end
    if (!sclk && psclk) begin
      if (CHK) begin
        if (nf == 0 && (cyc - t_fs) * NS_PER < 8) viol++;
        if ((cyc - t_rise) * NS_PER < 25) viol++;
        if ((cyc - t_d) * NS_PER < 8) viol++;
      end
      w = {w[14:0], sdo}; nf++; t_fall = cyc;
    end
    if (fs_n && !pfs) begin
      if (CHK && (cyc - t_fall) * NS_PER < 10) viol++;
      t_fsr = cyc;
    end
    if (cs_n && !pcs) begin
      if (CHK && (!fs_n || (cyc - t_fsr) * NS_PER < 20)) viol++;
      word = w; falls = nf; low8 = l8; frames++;
    end
    pcs = cs_n; pfs = fs_n; psclk = sclk; psdo = sdo;
  end

  assign frames_o = frames;
  assign word_o   = word;
  assign falls_o  = falls;
  assign low8_o   = low8;
  assign period_o = period;
  assign viol_o   = viol;
endmodule

module tb_wavedac_driver;
  localparam int HALF   = 7;
  localparam int RELOAD = 299;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [15:0] reload;
  logic        sel, bmode, fast, pd;
  logic        cs_n, fs_n, sclk, sdo, ovr;
  logic        f_cs_n, f_fs_n, f_sclk, f_sdo, f_ovr;

  wavedac_driver #(.TIMER_W(16), .CLK_HALF(HALF), .CLK_NS(4)) dut (
    .clk(clk), .rst_n(rst_n), .reload_i(reload), .sine_sel_i(sel),
    .byte_mode_i(bmode), .fast_i(fast), .pdown_i(pd),
    .dac_cs_n_o(cs_n), .dac_fs_n_o(fs_n), .dac_sclk_o(sclk),
    .dac_sdo_o(sdo), .overrun_o(ovr));

  // Quick instance: one-cycle half period, used for the full ramp wrap
  wavedac_driver #(.TIMER_W(16), .CLK_HALF(1), .CLK_NS(25)) dut_fast (
    .clk(clk), .rst_n(rst_n), .reload_i(16'd39), .sine_sel_i(1'b0),
    .byte_mode_i(1'b0), .fast_i(1'b1), .pdown_i(1'b0),
    .dac_cs_n_o(f_cs_n), .dac_fs_n_o(f_fs_n), .dac_sclk_o(f_sclk),
    .dac_sdo_o(f_sdo), .overrun_o(f_ovr));

  int m_frames, m_falls, m_low8, m_period, m_viol;
  logic [15:0] m_word;
  tb_frame_mon #(.NS_PER(4), .CHK(1'b1)) mon (
    .clk(clk), .cs_n(cs_n), .fs_n(fs_n), .sclk(sclk), .sdo(sdo),
    .frames_o(m_frames), .word_o(m_word), .falls_o(m_falls),
    .low8_o(m_low8), .period_o(m_period), .viol_o(m_viol));

  int f_frames, f_falls, f_low8, f_period, f_viol;
  logic [15:0] f_word;
  tb_frame_mon #(.NS_PER(25), .CHK(1'b0)) mon_fast (
    .clk(clk), .cs_n(f_cs_n), .fs_n(f_fs_n), .sclk(f_sclk), .sdo(f_sdo),
    .frames_o(f_frames), .word_o(f_word), .falls_o(f_falls),
    .low8_o(f_low8), .period_o(f_period), .viol_o(f_viol));

  int n_chk = 0, n_bad = 0;
  int ovr_cnt = 0;
  int rp = 0, sp = 0;
  int f_seen = 0, f_bad = 0;
  logic [15:0] f_w1023 = '0, f_w1024 = '0;

  always @(negedge clk) if (rst_n && ovr) ovr_cnt++;

  always @(negedge clk) begin
    if (f_frames != f_seen) begin
      if (f_word !== {1'b0, 1'b1, 1'b0, 1'b0, 10'(f_seen % 1024), 2'b00}) f_bad++;
      if (f_seen == 1023) f_w1023 = f_word;
      if (f_seen == 1024) f_w1024 = f_word;
      f_seen++;
    end
  end

  // {sine_sel, byte_mode, fast, pdown, frame count}
  localparam logic [11:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd3},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'd2},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'd3},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'd4},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'd2},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'd30}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sine_code(input int k);
    real s, m;
    int r;
    s = $sin(2.0 * 3.14159265358979 * k / 32.0);
    m = 511.0 * (s < 0.0 ? -s : s);
    r = $rtoi(m + 0.5);
    return (s < 0.0) ? 512 - r : 512 + r;
  endfunction

  function automatic logic [15:0] next_word(input logic s, input logic f, input logic p);
    int code;
    if (s) begin code = sine_code(sp); sp = (sp + 1) % 32; end
    else   begin code = rp;            rp = (rp + 1) % 1024; end
    return {1'b0, f, p, 1'b0, 10'(code), 2'b00};
  endfunction

  task automatic wait_frame();
    int f0;
    f0 = m_frames;
    while (m_frames == f0) @(negedge clk);
  endtask

  task automatic check_frame(input logic [15:0] exp, input logic b, input string req, input bit chk_period);
    check(m_word === exp, req, int'(m_word), int'(exp));
    check(m_falls == 16, "R3", m_falls, 16);
    check(m_low8 == (b ? 2 * HALF : HALF), "R8", m_low8, b ? 2 * HALF : HALF);
    check(m_viol == 0, "R4", m_viol, 0);
    if (chk_period) check(m_period == RELOAD + 1, "R2", m_period, RELOAD + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] exp;
    logic os, ob, of, op;
    int ov0;
    bit first;
    rst_n = 1'b0;
    reload = 16'(RELOAD);
    sel = VEC[0][11]; bmode = VEC[0][10]; fast = VEC[0][9]; pd = VEC[0][8];
    repeat (4) @(negedge clk);
    // R1: idle levels in reset
    check(cs_n === 1'b1 && fs_n === 1'b1, "R1", int'({cs_n, fs_n}), 3);
    check(sclk === 1'b0 && sdo === 1'b0 && ovr === 1'b0, "R1", int'({sclk, sdo, ovr}), 0);
    rst_n = 1'b1;
    first = 1'b1;

    // Table walk: each vector sets the inputs, then frames are compared
    for (int v = 0; v < 6; v++) begin
      sel = VEC[v][11]; bmode = VEC[v][10]; fast = VEC[v][9]; pd = VEC[v][8];
      for (int k = 0; k < int'(VEC[v][7:0]); k++) begin
        exp = next_word(sel, fast, pd);
        wait_frame();
        check_frame(exp, bmode, sel ? "R7" : "R6", !first);
        first = 1'b0;
      end
    end
    // R1: first sine value seen after reset was index 0 (covered above); no overruns so far
    check(ovr_cnt == 0, "R9", ovr_cnt, 0);

    // R10: inputs changed mid-frame do not alter the frame in flight
    os = sel; ob = bmode; of = fast; op = pd;
    while (cs_n !== 1'b0) @(negedge clk);
    sel = 1'b0; bmode = 1'b1; fast = 1'b1; pd = 1'b1;
    exp = next_word(os, of, op);
    wait_frame();
    check_frame(exp, ob, "R10", 1'b1);
    exp = next_word(1'b0, 1'b1, 1'b1);
    wait_frame();
    check_frame(exp, 1'b1, "R10", 1'b1);

    // R9: period shorter than a frame -> dropped expiries, no skipped samples
    bmode = 1'b0; fast = 1'b0; pd = 1'b0;
    reload = 16'd100;
    ov0 = ovr_cnt;
    for (int k = 0; k < 3; k++) begin
      exp = next_word(1'b0, 1'b0, 1'b0);
      wait_frame();
      check(m_word === exp, "R9", int'(m_word), int'(exp));
      check(m_viol == 0, "R4", m_viol, 0);
    end
    check(ovr_cnt - ov0 >= 3, "R9", ovr_cnt - ov0, 3);

    // R6: ramp wrap on the quick instance
    while (f_seen < 1026) @(negedge clk);
    check(f_w1023[11:2] == 10'd1023, "R6", int'(f_w1023[11:2]), 1023);
    check(f_w1024[11:2] == 10'd0, "R6", int'(f_w1024[11:2]), 0);
    check(f_bad == 0, "R6", f_bad, 0);
    check(f_falls == 16, "R3", f_falls, 16);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule